// File: doc/BRIEF.md
# Display Self-Test Sequencer

This block runs the power-on style self-test of a dot-matrix character display controller. A one-cycle start strobe, produced when software sets the self-test request bit (bit 6) of the control word, launches a run that lasts a fixed budget of 2^CNT_W clocks (2^18 by default). During the first clocks of the run the block walks the character-decoder ROM from address zero to the last address. It folds every returned word into a 16-bit modulo sum. When the run ends it compares that sum with a constant given as a parameter.

For the whole run the block also drives a test image to the LED column drivers. In the first half of the run, every other dot is lit, offset by one on alternate scan rows. In the second half the image is inverted. The display row scanner supplies the row parity. At the last cycle the block writes the verdict to the read-only pass bit (bit 5 of the control word). It then emits a one-cycle done pulse. The surrounding controller uses that pulse to blank the character RAM, clear the flash RAM and the other control bits, and set the user-glyph address register to all ones. The busy flag doubles as the read-back of the request bit, so the request bit clears itself when the run ends. While busy is high, the controller must block display accesses.

Top module: `selftest_engine`

## Requirements
- R1: After reset, busy_o, done_o, pass_o, pat_valid_o and rom_en_o are 0 and pat_dots_o is all zeros.
- R2: A start_i pulse sampled while busy_o is 0 raises busy_o on the next cycle. busy_o then stays high for exactly 2^CNT_W consecutive cycles.
- R3: A start_i sampled while busy_o is 1 is ignored. The run's length, its ROM sweep and its verdict are unchanged.
- R4: In the first ROM_DEPTH cycles of a run, rom_en_o is 1 and rom_addr_o counts 0, 1, ... ROM_DEPTH-1, one step per cycle. At all other times rom_en_o is 0.
- R5: The ROM answers one cycle after the address is presented. The checksum is the sum, modulo 2^16, of the rom_data_i words that return for the ROM_DEPTH addresses.
- R6: pass_o is updated only in the cycle where done_o is 1. It then shows 1 if the checksum equals EXP_SUM and 0 otherwise. At all other times it holds its value, including throughout a later run.
- R7: While busy_o is 1, pat_valid_o is 1. In the first half of the run (counter MSB 0), dot j of pat_dots_o is lit if and only if (j is even) XOR row_odd_i. In the second half every dot is inverted. While busy_o is 0, pat_dots_o is all zeros and pat_valid_o is 0.
- R8: done_o is a single-cycle pulse. It is high exactly in the first cycle after busy_o falls.
- R9: A start_i sampled in the same cycle as done_o is accepted. busy_o is 1 in the next cycle, and the verdict of the finished run is still published in pass_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Self-test request strobe (write of control bit 6) |
| rom_en_o | output | 1 | ROM read enable during the sweep |
| rom_addr_o | output | ROM_AW | Character-decoder ROM address |
| rom_data_i | input | ROM_DW | ROM word, one cycle after its address |
| row_odd_i | input | 1 | Parity of the row currently scanned |
| pat_dots_o | output | PAT_W | Dot pattern for the LED column drivers |
| pat_valid_o | output | 1 | Pattern overrides normal display data |
| busy_o | output | 1 | Test running; read-back of control bit 6 |
| pass_o | output | 1 | Verdict, read-only control bit 5 (1 = pass) |
| done_o | output | 1 | One-cycle end pulse that starts memory reinitialisation |

## Verification
The two functions that can meet in one cycle are the end of a run and the launch of the next. The done pulse and the verdict update fall in the first idle cycle, and a new request can be sampled in that same cycle. The bench holds start_i high exactly in the done cycle. It checks that the verdict of the old run appears and that busy_o returns on the very next cycle. The following run uses altered ROM contents, so the next verdict must flip from pass to fail. Start pulses injected in the middle of a run also check that the window length and the checksum stay undisturbed.

// File: rtl/st_pkg.sv
package st_pkg;
  localparam int unsigned CHK_W = 16;
  typedef enum logic { ST_IDLE = 1'b0, ST_RUN = 1'b1 } st_state_e;
endpackage

// File: rtl/st_timer.sv
module st_timer #(
  parameter int unsigned CNT_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             accept_o,
  output logic             last_o,
  output logic [CNT_W-1:0] cnt_o
);
  import st_pkg::*;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  st_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_q, done_d;
  logic             cnt_en;

  assign accept_o = (state_q == ST_IDLE) && start_i;
  assign last_o   = (state_q == ST_RUN) && (cnt_q == CNT_MAX);
  assign cnt_en   = accept_o || (state_q == ST_RUN);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    done_d  = 1'b0;
    if (accept_o) begin
      state_d = ST_RUN;
      cnt_d   = '0;
    end else if (last_o) begin
      state_d = ST_IDLE;
      done_d  = 1'b1;
    end else if (state_q == ST_RUN) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign busy_o = (state_q == ST_RUN);
  assign done_o = done_q;
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/st_rom_sweep.sv
module st_rom_sweep #(
  parameter int unsigned CNT_W  = 18,
  parameter int unsigned ROM_AW = 7,
  parameter int unsigned ROM_DW = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     busy_i,
  input  logic                     accept_i,
  input  logic [CNT_W-1:0]         cnt_i,
  output logic                     rom_en_o,
  output logic [ROM_AW-1:0]        rom_addr_o,
  input  logic [ROM_DW-1:0]        rom_data_i,
  output logic [st_pkg::CHK_W-1:0] sum_o
);
  import st_pkg::*;
  localparam int unsigned      ROM_DEPTH = 1 << ROM_AW;
  localparam logic [CNT_W-1:0] SWEEP_END = CNT_W'(ROM_DEPTH);

  logic             rd_vld_q;
  logic [CHK_W-1:0] sum_q, sum_d;
  logic             sum_en;

  assign rom_en_o   = busy_i && (cnt_i < SWEEP_END);
  assign rom_addr_o = cnt_i[ROM_AW-1:0];
  assign sum_en     = accept_i || rd_vld_q;

  always_comb begin
    if (accept_i) sum_d = '0;
    else          sum_d = sum_q + CHK_W'(rom_data_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_vld_q <= 1'b0;
    else        rd_vld_q <= rom_en_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sum_q <= '0;
    else if (sum_en) sum_q <= sum_d;
  end

  assign sum_o = sum_q;
endmodule

// File: rtl/st_pattern.sv
module st_pattern #(
  parameter int unsigned PAT_W = 5
) (
  input  logic             busy_i,
  input  logic             phase_i,
  input  logic             row_odd_i,
  output logic [PAT_W-1:0] dots_o
);
  for (genvar j = 0; j < PAT_W; j++) begin : g_dot
    localparam logic EVEN_COL = ((j % 2) == 0);
    assign dots_o[j] = busy_i & (EVEN_COL ^ row_odd_i ^ phase_i);
  end
endmodule

// File: rtl/selftest_engine.sv
module selftest_engine #(
  parameter int unsigned CNT_W   = 18,
  parameter int unsigned ROM_AW  = 7,
  parameter int unsigned ROM_DW  = 8,
  parameter int unsigned PAT_W   = 5,
  parameter logic [15:0] EXP_SUM = 16'h0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  output logic              rom_en_o,
  output logic [ROM_AW-1:0] rom_addr_o,
  input  logic [ROM_DW-1:0] rom_data_i,
  input  logic              row_odd_i,
  output logic [PAT_W-1:0]  pat_dots_o,
  output logic              pat_valid_o,
  output logic              busy_o,
  output logic              pass_o,
  output logic              done_o
);
  import st_pkg::*;

  logic             rst_meta_q, rst_n_q;
  logic             busy, accept, last;
  logic [CNT_W-1:0] cnt;
  logic [CHK_W-1:0] sum;
  logic             pass_q, pass_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_n_q    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_n_q    <= rst_meta_q;
    end
  end

  st_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n_q), .start_i(start_i),
    .busy_o(busy), .done_o(done_o), .accept_o(accept),
    .last_o(last), .cnt_o(cnt)
  );

  st_rom_sweep #(.CNT_W(CNT_W), .ROM_AW(ROM_AW), .ROM_DW(ROM_DW)) u_sweep (
    .clk(clk), .rst_n(rst_n_q), .busy_i(busy), .accept_i(accept),
    .cnt_i(cnt), .rom_en_o(rom_en_o), .rom_addr_o(rom_addr_o),
    .rom_data_i(rom_data_i), .sum_o(sum)
  );

  st_pattern #(.PAT_W(PAT_W)) u_pat (
    .busy_i(busy), .phase_i(cnt[CNT_W-1]), .row_odd_i(row_odd_i),
    .dots_o(pat_dots_o)
  );

  assign pass_d = (sum == EXP_SUM);

  always_ff @(posedge clk or negedge rst_n_q) begin
    if (!rst_n_q) pass_q <= 1'b0;
    else if (last) pass_q <= pass_d;
  end

  assign busy_o      = busy;
  assign pat_valid_o = busy;
  assign pass_o      = pass_q;
endmodule

// File: rtl/selftest_engine_chk.sv
module selftest_engine_chk #(
  parameter int unsigned CNT_W  = 18,
  parameter int unsigned ROM_AW = 7,
  parameter int unsigned PAT_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              pass,
  input logic              rom_en,
  input logic [ROM_AW-1:0] rom_addr,
  input logic [PAT_W-1:0]  dots,
  input logic              pat_valid
);
  localparam logic [CNT_W:0] RUN_LEN = (CNT_W+1)'(1) << CNT_W;
  logic [CNT_W:0] len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    len_q <= '0;
    else if (busy) len_q <= len_q + 1'b1;
    else           len_q <= '0;
  end

  AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n) (!busy && start) |=> busy); // R2
  AST_RUN_LENGTH: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> (len_q == RUN_LEN)); // R3
  AST_SWEEP_FIRST: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> (rom_en && rom_addr == '0)); // R4
  AST_SWEEP_STEP: assert property (@(posedge clk) disable iff (!rst_n) (rom_en && $past(rom_en)) |-> (rom_addr == ROM_AW'($past(rom_addr) + 1'b1))); // R4
  AST_SWEEP_IDLE: assert property (@(posedge clk) disable iff (!rst_n) rom_en |-> busy); // R4
  AST_VERDICT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !done |-> $stable(pass)); // R6
  AST_IDLE_DARK: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> (dots == '0 && !pat_valid)); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R8
  AST_DONE_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n) done |-> (!busy && $past(busy))); // R8
endmodule

bind selftest_engine selftest_engine_chk #(.CNT_W(CNT_W), .ROM_AW(ROM_AW), .PAT_W(PAT_W)) u_chk (
  .clk(clk), .rst_n(rst_n_q), .start(start_i), .busy(busy_o), .done(done_o),
  .pass(pass_o), .rom_en(rom_en_o), .rom_addr(rom_addr_o), .dots(pat_dots_o),
  .pat_valid(pat_valid_o)
);

// File: tb/sim_selftest_engine.sv
module sim_selftest_engine;
  localparam int unsigned CNT_W  = 10;
  localparam int unsigned ROM_AW = 5;
  localparam int unsigned ROM_DW = 8;
  localparam int unsigned PAT_W  = 8;
  localparam int unsigned DEPTH  = 1 << ROM_AW;
  localparam int unsigned RUN    = 1 << CNT_W;

  function automatic logic [7:0] rom_word(input int unsigned a, input bit bad);
    logic [7:0] w;
    w = 8'((a * 37 + 5) & 8'hff);
    if (bad && a == 9) w = w ^ 8'h01;
    return w;
  endfunction

  function automatic logic [15:0] ref_sum(input bit bad);
    logic [15:0] s;
    s = '0;
    for (int a = 0; a < DEPTH; a++) s = s + 16'(rom_word(a, bad));
    return s;
  endfunction

  localparam logic [15:0] GOOD_SUM = ref_sum(1'b0);

  logic clk, rst_n, start, row_odd;
  logic rom_en, pat_valid, busy, pass, done;
  logic [ROM_AW-1:0] rom_addr;
  logic [ROM_DW-1:0] rom_q;
  logic [PAT_W-1:0]  dots;
  bit corrupt;
  int checks, fails;

  selftest_engine #(.CNT_W(CNT_W), .ROM_AW(ROM_AW), .ROM_DW(ROM_DW),
                    .PAT_W(PAT_W), .EXP_SUM(GOOD_SUM)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start), .rom_en_o(rom_en),
    .rom_addr_o(rom_addr), .rom_data_i(rom_q), .row_odd_i(row_odd),
    .pat_dots_o(dots), .pat_valid_o(pat_valid), .busy_o(busy),
    .pass_o(pass), .done_o(done)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) if (rom_en) rom_q <= rom_word(int'(rom_addr), corrupt);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R2 watchdog expired: actual hung expected finish");
    summary();
  end

  // One full run; chained = start already accepted in the previous done cycle.
  task automatic run_once(input bit exp_pass, input bit prev_pass, input bit poke,
                          input bit chain_next, input bit chained);
    int k;
    int bad_addr, bad_dots, bad_hold;
    logic [PAT_W-1:0] want;
    bit ph;
    k = 0; bad_addr = 0; bad_dots = 0; bad_hold = 0;
    if (!chained) begin
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    check("R2 busy after start", 32'(busy), 32'd1);
    while (busy && k < RUN + 4) begin
      row_odd = k[2];
      start   = poke && (k == 100 || k == 700);
      #1;
      if (rom_en !== (k < DEPTH)) bad_addr++;
      if (k < DEPTH && rom_addr !== ROM_AW'(k)) bad_addr++;
      ph = (k >= RUN / 2);
      for (int j = 0; j < PAT_W; j++) want[j] = ((j % 2) == 0) ^ row_odd ^ ph;
      if (dots !== want || pat_valid !== 1'b1) bad_dots++;
      if (pass !== prev_pass || done !== 1'b0) bad_hold++;
      @(negedge clk);
      k++;
    end
    start = 1'b0;
    check("R2/R3 run length", 32'(k), 32'(RUN));
    check("R4 sweep addresses", 32'(bad_addr), 32'd0);
    check("R7 dot pattern", 32'(bad_dots), 32'd0);
    check("R6 verdict held during run", 32'(bad_hold), 32'd0);
    check("R8 done after busy falls", 32'(done), 32'd1);
    check("R5/R6 verdict", 32'(pass), 32'(exp_pass));
    check("R7 idle dark", 32'({pat_valid, dots}), 32'd0);
    if (chain_next) begin
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check("R9 restart in done cycle", 32'(busy), 32'd1);
      check("R9 verdict kept", 32'(pass), 32'(exp_pass));
    end else begin
      @(negedge clk);
      check("R8 done one cycle", 32'(done), 32'd0);
      check("R2 idle after run", 32'(busy), 32'd0);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 reset outputs", 32'({busy, done, pass, pat_valid, rom_en}), 32'd0);
    check("R1 reset dots", 32'(dots), 32'd0);
  endtask

  task automatic t_good_run();
    run_once(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_ignore_start();
    run_once(1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_chain_then_fail();
    run_once(1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
    corrupt = 1'b1;
    run_once(1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
    corrupt = 1'b0;
  endtask

  task automatic t_reset_mid_run();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (50) @(negedge clk);
    check("R2 busy mid run", 32'(busy), 32'd1);
    t_reset();
  endtask

  initial begin
    checks = 0; fails = 0;
    start = 1'b0; row_odd = 1'b0; corrupt = 1'b0;
    t_reset();
    t_good_run();
    t_ignore_start();
    t_chain_then_fail();
    t_good_run_after_fail();
    t_reset_mid_run();
    summary();
  end

  task automatic t_good_run_after_fail();
    run_once(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask
endmodule